// File: doc/BRIEF.md
# Page-Buffered Timed Write Commit Controller

This block sits behind the bus front end of a serial byte-wide memory. It gathers the data bytes of one write transaction into a page-sized staging buffer. Nothing reaches the storage array until the transaction closes with a stop. At that stop the staged bytes are copied into a synchronous array, one byte per cycle. A busy window of fixed length is held open while the copy runs. The front end uses busy to withhold every acknowledge until the window closes. That lets a host poll for completion by sending new starts.

The word address that comes with the start-of-write strobe is split into two parts. The upper bits select a page row. The lower bits give the first position inside the page. Each later byte moves to the next position and wraps at the end of the same page. Only the positions that received a byte are written, so a partial page leaves its other bytes unchanged. A write-protect input held high at the stop drops the whole transaction. A transaction that carried no data bytes is also dropped, which covers the address-only write used to set up a random read. The length of the busy window is a parameter counted in clock cycles.

Top module: `page_commit_ctrl`

## Requirements
- R1: A page holds 2^PAGE_W bytes. A byte is staged at position wr_addr[PAGE_W-1:0] plus the number of bytes already received in the transaction, taken modulo the page size. A byte arriving at a position already staged replaces the earlier one.
- R2: A commit writes only the page row wr_addr[ADDR_W-1:PAGE_W] given at the start. It writes each staged position exactly once, and no other address of the array changes.
- R3: A stop strobe commits when data bytes are staged and wp is low. busy goes high on the clock edge that samples that stop and stays high for exactly BUSY_CYCLES cycles. Array writes (mem_we) occur only while busy is high.
- R4: While busy is high, the wr_start, byte_stb, stop_stb and abort_stb strobes have no effect. They neither change the data being committed nor start or extend a transaction.
- R5: A stop sampled while wp is high commits nothing, discards the staged bytes and leaves busy low.
- R6: A stop that follows a start with no data byte commits nothing and leaves busy low.
- R7: An abort_stb, or a new wr_start, discards every staged byte of the current transaction without writing it.
- R8: After reset, busy and mem_we are low and nothing is staged. A byte strobe with no preceding start is ignored.
- R9: Commit writes go out in ascending address order, and all of them finish before busy falls. This requires BUSY_CYCLES >= 2^PAGE_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start-of-write strobe; samples wr_addr |
| wr_addr | input | ADDR_W | Word address of the write |
| byte_stb | input | 1 | A data byte was received |
| byte_data | input | 8 | Data byte |
| stop_stb | input | 1 | Valid stop on the bus |
| abort_stb | input | 1 | Start or read that ends the write without a stop |
| wp | input | 1 | Write-protect pin, high blocks the array |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit in progress; front end withholds acknowledges |

## Verification
The assertions assume that the front end raises at most one of the four strobes in any cycle. They also assume wp is steady in the cycle a stop is sampled and that BUSY_CYCLES covers a full page scan. The bench changes every input on the falling clock edge and pulses exactly one strobe per cycle. The ordering and window checks therefore see single, well-formed events. Strobes sent during the busy window are deliberate: they test that busy shields the staged state. The bench never sends them while a staging step is half applied.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef logic [7:0] byte_t;

    // Staging progress of one write transaction
    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,   // no write open
        STG_ADDR = 2'd1,   // address loaded, no data yet
        STG_DATA = 2'd2    // at least one byte staged
    } stg_state_e;

    // Bus events delivered by the front end, at most one per cycle
    typedef struct packed {
        logic start;
        logic data;
        logic stop;
        logic abort;
    } bus_evt_t;

    function automatic bus_evt_t pack_evt(input logic s, input logic d,
                                          input logic p, input logic a);
        bus_evt_t e;
        e.start = s;
        e.data  = d;
        e.stop  = p;
        e.abort = a;
        return e;
    endfunction

endpackage

// File: rtl/pgc_stage_buf.sv
module pgc_stage_buf
    import pgc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          accept,
    input  bus_evt_t                      evt,
    input  logic [ADDR_W-1:0]             addr_in,
    input  byte_t                         data_in,
    input  logic                          wp,
    input  logic                          scan_done,
    output logic [ADDR_W-PAGE_W-1:0]      row_o,
    output byte_t [(1<<PAGE_W)-1:0]       data_o,
    output logic [(1<<PAGE_W)-1:0]        valid_o,
    output logic                          commit_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;

    stg_state_e                  state_q;
    logic [ROW_W-1:0]            row_q;
    logic [PAGE_W-1:0]           ptr_q;
    byte_t [PAGE_BYTES-1:0]      data_q;
    logic [PAGE_BYTES-1:0]       valid_q;

    assign commit_o = accept && evt.stop && (state_q == STG_DATA) && !wp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_IDLE;
            row_q   <= '0;
            ptr_q   <= '0;
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            if (scan_done) begin
                valid_q <= '0;
            end
            if (accept) begin
                if (evt.start) begin
                    state_q <= STG_ADDR;
                    valid_q <= '0;
                    row_q   <= addr_in[ADDR_W-1:PAGE_W];
                    ptr_q   <= addr_in[PAGE_W-1:0];
                end else if (evt.abort) begin
                    state_q <= STG_IDLE;
                    valid_q <= '0;
                end else if (evt.data && state_q != STG_IDLE) begin
                    state_q        <= STG_DATA;
                    data_q[ptr_q]  <= data_in;
                    valid_q[ptr_q] <= 1'b1;
                    ptr_q          <= ptr_q + 1'b1;
                end else if (evt.stop) begin
                    state_q <= STG_IDLE;
                    if (!commit_o) begin
                        valid_q <= '0;
                    end
                end
            end
        end
    end

    assign row_o   = row_q;
    assign data_o  = data_q;
    assign valid_o = valid_q;

    // R4
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(row_q) && $stable(ptr_q) && $stable(data_q)));

endmodule

// File: rtl/pgc_busy_timer.sv
module pgc_busy_timer #(
    parameter int BUSY_W      = 20,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy_o
);
    localparam logic [BUSY_W-1:0] LOAD = BUSY_W'(BUSY_CYCLES);

    logic [BUSY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (go) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/pgc_commit_scan.sv
module pgc_commit_scan
    import pgc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go,
    input  logic [ADDR_W-PAGE_W-1:0]      row_i,
    input  byte_t [(1<<PAGE_W)-1:0]       data_i,
    input  logic [(1<<PAGE_W)-1:0]        valid_i,
    output logic                          mem_we_o,
    output logic [ADDR_W-1:0]             mem_addr_o,
    output byte_t                         mem_wdata_o,
    output logic                          done_o
);
    logic              scan_q;
    logic [PAGE_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= 1'b0;
            idx_q  <= '0;
        end else if (go) begin
            scan_q <= 1'b1;
            idx_q  <= '0;
        end else if (scan_q) begin
            idx_q <= idx_q + 1'b1;
            if (&idx_q) begin
                scan_q <= 1'b0;
            end
        end
    end

    assign done_o      = scan_q && (&idx_q);
    assign mem_we_o    = scan_q && valid_i[idx_q];
    assign mem_addr_o  = {row_i, idx_q};
    assign mem_wdata_o = data_i[idx_q];

    // R9
    scan_span_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_q && !(&idx_q)) |=> scan_q);

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pgc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int BUSY_W      = 20,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              stop_stb,
    input  logic              abort_stb,
    input  logic              wp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;

    bus_evt_t                 evt;
    logic [ROW_W-1:0]         stg_row;
    byte_t [PAGE_BYTES-1:0]   stg_data;
    logic [PAGE_BYTES-1:0]    stg_valid;
    logic                     commit_go;
    logic                     scan_done;

    assign evt = pack_evt(wr_start, byte_stb, stop_stb, abort_stb);

    pgc_stage_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .accept    (!busy),
        .evt       (evt),
        .addr_in   (wr_addr),
        .data_in   (byte_data),
        .wp        (wp),
        .scan_done (scan_done),
        .row_o     (stg_row),
        .data_o    (stg_data),
        .valid_o   (stg_valid),
        .commit_o  (commit_go)
    );

    pgc_busy_timer #(.BUSY_W(BUSY_W), .BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .go     (commit_go),
        .busy_o (busy)
    );

    pgc_commit_scan #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .go          (commit_go),
        .row_i       (stg_row),
        .data_i      (stg_data),
        .valid_i     (stg_valid),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .done_o      (scan_done)
    );

    // R3
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R3
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(stop_stb) && !$past(wp)));

    // R5
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_stb && wp && !busy) |=> !busy);

    // R6
    empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_stb && !busy && (stg_valid == '0)) |=> !busy);

    // R9
    commit_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr > $past(mem_addr)));

endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
    import pgc_pkg::*;

    localparam int AW    = 6;
    localparam int PW    = 3;
    localparam int BW    = 5;
    localparam int BC    = 12;
    localparam int PB    = 1 << PW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_start = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_stb = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop_stb = 1'b0;
    logic          abort_stb = 1'b0;
    logic          wp = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy;

    always #5 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_W(BW), .BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
        .abort_stb(abort_stb), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    logic [7:0] dut_mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    logic       mem_init = 1'b1;
    logic       cnt_clr  = 1'b0;
    int         we_count;

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < DEPTH; i++) dut_mem[i] <= 8'(i ^ 8'h5A);
        end else if (mem_we) begin
            dut_mem[mem_addr] <= mem_wdata;
        end
        if (cnt_clr) we_count <= 0;
        else if (mem_we) we_count <= we_count + 1;
    end

    int  vectors = 0;
    int  fails   = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic byte_t pat(input int a, input int k, input int t);
        return byte_t'((t * 37 + k * 11 + a * 3 + 1) & 255);
    endfunction

    task automatic send_start(input int a);
        wr_start = 1'b1; wr_addr = AW'(a);
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic send_byte(input byte_t d);
        byte_stb = 1'b1; byte_data = d;
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic send_stop(input bit w);
        wp = w; stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0; wp = 1'b0;
    endtask

    task automatic send_abort();
        abort_stb = 1'b1;
        @(negedge clk);
        abort_stb = 1'b0;
    endtask

    task automatic clear_count();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic measure_busy(output int c);
        c = 0;
        while (busy && c < 200) begin
            c++;
            @(negedge clk);
        end
    endtask

    task automatic compare_mem(input string tag);
        for (int i = 0; i < DEPTH; i++)
            check(dut_mem[i] == exp_mem[i], tag, dut_mem[i], exp_mem[i]);
    endtask

    // Full transaction: start at a, n bytes, stop with protect w
    task automatic page_write(input int a, input int n, input int t, input bit w, input string tag);
        int c;
        int row;
        int exp_n;
        bit exp_busy;
        row = a / PB;
        clear_count();
        send_start(a);
        for (int k = 0; k < n; k++) begin
            if (!w) exp_mem[row * PB + ((a + k) % PB)] = pat(a, k, t);
            send_byte(pat(a, k, t));
        end
        send_stop(w);
        exp_busy = !w && (n > 0);
        exp_n    = exp_busy ? ((n < PB) ? n : PB) : 0;
        measure_busy(c);
        // R3 busy window length
        check(c == (exp_busy ? BC : 0), {tag, " R3 busy length"}, c, exp_busy ? BC : 0);
        // R2 one write per staged position
        check(we_count == exp_n, {tag, " R2 write count"}, we_count, exp_n);
        compare_mem({tag, " R2 array contents"});
    endtask

    initial begin
        int c;
        int nlist [4] = '{1, 3, 8, 11};
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'(i ^ 8'h5A);
        repeat (3) @(negedge clk);
        rst = 1'b0; mem_init = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(busy == 1'b0, "R8 busy after reset", busy, 0);
        check(mem_we == 1'b0, "R8 mem_we after reset", mem_we, 0);
        // R8 orphan byte without start
        send_byte(8'hEE);
        send_stop(1'b0);
        check(busy == 1'b0, "R8 orphan byte no commit", busy, 0);
        compare_mem("R8 orphan byte array");

        // R1 / R2 / R3 / R9 sweep over every start address and several lengths
        for (int a = 0; a < DEPTH; a++)
            for (int ni = 0; ni < 4; ni++)
                page_write(a, nlist[ni], a * 4 + ni, 1'b0, "R1 sweep");

        // R5 write protect
        page_write(5, 4, 900, 1'b1, "R5 protect");
        page_write(62, 16, 901, 1'b1, "R5 protect full");

        // R6 address-only transaction
        send_start(10);
        send_stop(1'b0);
        check(busy == 1'b0, "R6 empty stop", busy, 0);

        // R7 abort after data
        send_start(17);
        send_byte(8'h11);
        send_byte(8'h22);
        send_abort();
        send_stop(1'b0);
        check(busy == 1'b0, "R7 abort no commit", busy, 0);
        compare_mem("R7 abort array");

        // R7 restart discards earlier bytes; only the second write lands
        send_start(20);
        send_byte(8'h33);
        send_byte(8'h44);
        page_write(33, 2, 950, 1'b0, "R7 restart");

        // R4 strobes during the busy window are ignored
        clear_count();
        send_start(40);
        for (int k = 0; k < 3; k++) begin
            exp_mem[40 + k] = pat(40, k, 960);
            send_byte(pat(40, k, 960));
        end
        send_stop(1'b0);
        check(busy == 1'b1, "R3 busy after stop", busy, 1);
        send_start(8);
        send_byte(8'h77);
        send_stop(1'b0);
        measure_busy(c);
        check(c == BC - 3, "R4 busy not extended", c, BC - 3);
        check(we_count == 3, "R4 write count", we_count, 3);
        compare_mem("R4 array after busy");
        send_byte(8'h99);
        send_stop(1'b0);
        check(busy == 1'b0, "R4 start during busy was ignored", busy, 0);
        compare_mem("R4 array final");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule